// File: doc/BRIEF.md
# Direct-Mapped Word Cache with Run-Time Write Policy

This block is a small data cache controller. It sits between a processor load/store port and a slower, word-addressed memory. The cache is direct-mapped and has eight lines of one word each. Each line keeps a valid flag, a dirty flag, a tag and a data word. The low three bits of the word address select the line, and the remaining bits form the tag.

Two static configuration inputs set how stores behave. The first selects write-through or write-back. The second selects whether a store miss installs the written word in the cache (allocate) or bypasses the cache (no-allocate). Loads that hit, and stores that need no memory traffic, finish in the cycle they are presented. Any access that needs the memory holds the processor off with a low ready until that work is done. Under write-back, replacing a valid dirty line first writes its old word back to memory, which adds one memory transaction to the stall.

The processor side uses a request/ready handshake. The processor holds the request and its fields until it samples ready high at a clock edge. The memory side uses a request/acknowledge handshake of any latency, with read data valid in the acknowledge cycle.

Top module: `dmc_top`

## Requirements
- R1: After reset, every line is invalid and clean, so the first load to any address performs exactly one memory read and no memory write.
- R2: In write-through mode, every store writes its word to memory at the store's address. A store that hits also updates the cached word, so a later load of that address hits and returns the new word.
- R3: In write-through mode with allocate, a store to a line that holds a different tag replaces the tag and the data without any write-back. A later load of the new address hits, and a load of the old address misses and refills from memory.
- R4: Under no-allocate, a store miss writes memory only and leaves the cache unchanged. A load of the address the line already held still hits with its old word, and a load of the stored address misses and returns the stored word from memory.
- R5: In write-back mode, a store hit updates the line and marks it dirty. It causes no memory transaction, and ready is high in the request cycle.
- R6: In write-back mode, replacing a valid dirty line first issues one memory write of the old word to the old line's address (old tag concatenated with the index). Only after that does the refill or install take place.
- R7: A load miss reads the word from memory, fills the line with valid set and dirty cleared, and returns the word to the processor. A line that was filled this way needs no write-back when it is later replaced.
- R8: Ready is never high while a memory request is outstanding. A load hit completes with ready high in the request cycle.
- R9: The memory request, its address, write flag and write data stay stable until acknowledged. Results are correct for any memory latency.
- R10: In write-back mode with allocate, a store miss to an invalid or clean line installs the word as dirty with no memory transaction, and it completes in the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_write_back | input | 1 | 1 selects write-back, 0 selects write-through (static) |
| cfg_write_alloc | input | 1 | 1 selects allocate on a store miss, 0 selects no-allocate (static) |
| cpu_req | input | 1 | Processor access request, held until ready |
| cpu_we | input | 1 | 1 for a store, 0 for a load |
| cpu_addr | input | ADDR_W | Word address; bits [2:0] index the line |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | Access completes at this clock edge |
| cpu_rdata | output | DATA_W | Load data, valid with cpu_ready |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 for a memory write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory completes the transaction (one-cycle pulse) |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ack |

## Verification
A wrong tag, valid or dirty bit in this block does not show at once. It shows on the next access to the same line: a memory transaction count that is off by one, a write-back that should or should not happen, or a load that returns a stale word. The bench therefore follows each store with loads of the stored address and of the address the line held before. For every access it counts the reads and writes that reach memory. For each eviction it checks the order, address and data of the memory transactions, so a bad state is caught within one or two accesses of its cause.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_EVICT  = 3'd1,
    ST_REFILL = 3'd2,
    ST_STORE  = 3'd3,
    ST_DONE   = 3'd4
  } st_e;
endpackage

// File: rtl/dmc_lines.sv
module dmc_lines #(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic              rd_dirty,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_dirty
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0]  v_all;
  logic [LINES-1:0]  d_all;
  logic [TAG_W-1:0]  t_all [LINES];
  logic [DATA_W-1:0] w_all [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic              v_q, d_q;
    logic [TAG_W-1:0]  t_q;
    logic [DATA_W-1:0] w_q;
    logic              sel;

    assign sel = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
      end else if (sel) begin
        v_q <= 1'b1;
        d_q <= wr_dirty;
      end
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        t_q <= wr_tag;
        w_q <= wr_data;
      end
    end

    assign v_all[g] = v_q;
    assign d_all[g] = d_q;
    assign t_all[g] = t_q;
    assign w_all[g] = w_q;
  end

  assign rd_valid = v_all[rd_idx];
  assign rd_dirty = d_all[rd_idx];
  assign rd_tag   = t_all[rd_idx];
  assign rd_data  = w_all[rd_idx];
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wb_mode,
  input  logic alloc_mode,
  input  logic req,
  input  logic we,
  input  logic hit,
  input  logic victim_dirty,
  input  logic mem_ack,
  output st_e  st,
  output logic ready,
  output logic mem_req,
  output logic mem_we,
  output logic sel_evict,
  output logic line_fill,
  output logic line_store
);
  st_e st_q, st_d;
  logic fast;

  always_comb begin
    fast = (!we && hit) ||
           (we && wb_mode && (hit || (alloc_mode && !victim_dirty)));
  end

  always_comb begin
    st_d      = st_q;
    ready     = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    sel_evict = 1'b0;
    line_fill = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req) begin
          if (fast) begin
            ready = 1'b1;
          end else if (!we) begin
            st_d = (wb_mode && victim_dirty) ? ST_EVICT : ST_REFILL;
          end else if (wb_mode && alloc_mode) begin
            st_d = ST_EVICT;
          end else begin
            st_d = ST_STORE;
          end
        end
      end
      ST_EVICT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        sel_evict = 1'b1;
        if (mem_ack) st_d = we ? ST_DONE : ST_REFILL;
      end
      ST_REFILL: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          line_fill = 1'b1;
          st_d      = ST_DONE;
        end
      end
      ST_STORE: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        if (mem_ack) st_d = ST_DONE;
      end
      ST_DONE: begin
        ready = 1'b1;
        st_d  = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
    line_store = ready && we && (hit || alloc_mode);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign st = st_q;
endmodule

// File: rtl/dmc_top.sv
module dmc_top
  import dmc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_write_back,
  input  logic              cfg_write_alloc,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [1:0] rs_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic              ln_valid, ln_dirty;
  logic [TAG_W-1:0]  ln_tag;
  logic [DATA_W-1:0] ln_data;
  logic              lu_hit, victim_dirty;
  st_e               st;
  logic              sel_evict, line_fill, line_store;
  logic              wr_en, wr_dirty;
  logic [DATA_W-1:0] wr_data;

  assign idx          = cpu_addr[IDX_W-1:0];
  assign tag          = cpu_addr[ADDR_W-1:IDX_W];
  assign lu_hit       = ln_valid && (ln_tag == tag);
  assign victim_dirty = ln_valid && ln_dirty;

  dmc_ctrl ctrl_i (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .wb_mode      (cfg_write_back),
    .alloc_mode   (cfg_write_alloc),
    .req          (cpu_req),
    .we           (cpu_we),
    .hit          (lu_hit),
    .victim_dirty (victim_dirty),
    .mem_ack      (mem_ack),
    .st           (st),
    .ready        (cpu_ready),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .sel_evict    (sel_evict),
    .line_fill    (line_fill),
    .line_store   (line_store)
  );

  assign wr_en    = line_fill || line_store;
  assign wr_data  = line_fill ? mem_rdata : cpu_wdata;
  assign wr_dirty = line_store && cfg_write_back;

  dmc_lines #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) lines_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rd_idx   (idx),
    .rd_valid (ln_valid),
    .rd_dirty (ln_dirty),
    .rd_tag   (ln_tag),
    .rd_data  (ln_data),
    .wr_en    (wr_en),
    .wr_idx   (idx),
    .wr_tag   (tag),
    .wr_data  (wr_data),
    .wr_dirty (wr_dirty)
  );

  assign mem_addr  = sel_evict ? {ln_tag, idx} : cpu_addr;
  assign mem_wdata = sel_evict ? ln_data : cpu_wdata;
  assign cpu_rdata = ln_data;
endmodule

// File: rtl/dmc_chk.sv
module dmc_chk
  import dmc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_write_back,
  input logic              cpu_req,
  input logic              cpu_we,
  input logic              cpu_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ack,
  input logic              lu_hit,
  input st_e               st
);
  AST_READY_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> !mem_req); // R8

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R9

  AST_WB_HIT_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_write_back && cpu_req && cpu_we && st == ST_IDLE && lu_hit) |-> cpu_ready); // R5

  AST_WT_STORE_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_write_back && cpu_req && cpu_we && st == ST_IDLE) |=> (mem_req && mem_we)); // R2

  AST_READ_HIT_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_we && st == ST_IDLE && lu_hit) |-> cpu_ready); // R8
endmodule

bind dmc_top dmc_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_write_back (cfg_write_back),
  .cpu_req        (cpu_req),
  .cpu_we         (cpu_we),
  .cpu_ready      (cpu_ready),
  .mem_req        (mem_req),
  .mem_we         (mem_we),
  .mem_addr       (mem_addr),
  .mem_wdata      (mem_wdata),
  .mem_ack        (mem_ack),
  .lu_hit         (lu_hit),
  .st             (st)
);

// File: tb/dmc_top_tb_top.sv
`timescale 1ns/1ps
module dmc_top_tb_top;
  localparam int AW = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, cfg_wb, cfg_al;
  logic cpu_req, cpu_we, cpu_ready;
  logic [AW-1:0] cpu_addr;
  logic [DW-1:0] cpu_wdata, cpu_rdata;
  logic mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  dmc_top #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_write_back(cfg_wb), .cfg_write_alloc(cfg_al),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int n_chk = 0, n_fail = 0;
  int lat = 1;
  int cnt = 0;
  int reads_n = 0, writes_n = 0, log_n = 0;
  logic [DW-1:0] mem [256];
  logic          log_we   [64];
  logic [AW-1:0] log_addr [64];
  logic [DW-1:0] log_data [64];

  function automatic logic [DW-1:0] init_val(input int a);
    return DW'(16'h1000 + a * 7);
  endfunction

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = init_val(i);
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      cnt     <= 0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
      cnt     <= 0;
    end else if (mem_req) begin
      if (cnt >= lat) begin
        mem_ack <= 1'b1;
        log_we[log_n % 64]   <= mem_we;
        log_addr[log_n % 64] <= mem_addr;
        log_data[log_n % 64] <= mem_wdata;
        log_n <= log_n + 1;
        if (mem_we) begin
          mem[mem_addr] <= mem_wdata;
          writes_n <= writes_n + 1;
        end else begin
          mem_rdata <= mem[mem_addr];
          reads_n <= reads_n + 1;
        end
      end else begin
        cnt <= cnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic wb, input logic al);
    @(negedge clk);
    rst_n = 1'b0; cfg_wb = wb; cfg_al = al; cpu_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // One access; returns read data, cycles waited and memory traffic.
  task automatic access(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        output logic [DW-1:0] rd, output int ncyc, output int nrd,
                        output int nwr, output int lg0);
    int r0, w0;
    r0 = reads_n; w0 = writes_n; lg0 = log_n; ncyc = 0;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    forever begin
      #1;
      if (cpu_ready && mem_req) chk(1'b0, "R8 ready with mem_req", 1, 0);
      if (cpu_ready) break;
      @(negedge clk);
      ncyc++;
    end
    rd = cpu_rdata;
    @(negedge clk);
    cpu_req = 1'b0;
    nrd = reads_n - r0;
    nwr = writes_n - w0;
  endtask

  logic [DW-1:0] rd;
  int nc, nr, nw, lg;

  task automatic t_reset_and_fill();
    do_reset(1'b0, 1'b1);
    chk(cpu_ready == 1'b0, "R1 ready idle after reset", cpu_ready, 0);
    access(0, 8'h05, 0, rd, nc, nr, nw, lg);
    chk(nr == 1 && nw == 0, "R1 first load reads memory once", nr * 16 + nw, 16);
    chk(rd == init_val(5), "R7 refill data returned", rd, init_val(5));
    access(0, 8'h05, 0, rd, nc, nr, nw, lg);
    chk(nr + nw == 0 && nc == 0, "R8 load hit no traffic, same cycle", nc * 256 + nr + nw, 0);
    chk(rd == init_val(5), "R7 hit data", rd, init_val(5));
  endtask

  task automatic t_write_through();
    access(1, 8'h05, 16'hA111, rd, nc, nr, nw, lg);
    chk(nw == 1 && nr == 0, "R2 WT store hit writes memory", nw, 1);
    chk(mem[5] == 16'hA111, "R2 memory holds stored word", mem[5], 16'hA111);
    access(0, 8'h05, 0, rd, nc, nr, nw, lg);
    chk(rd == 16'hA111 && nr == 0, "R2 cached word updated", rd, 16'hA111);
    access(1, 8'h25, 16'hB222, rd, nc, nr, nw, lg);
    chk(nw == 1 && nr == 0 && log_addr[lg % 64] == 8'h25, "R3 replace store, single write", log_addr[lg % 64], 8'h25);
    access(0, 8'h25, 0, rd, nc, nr, nw, lg);
    chk(rd == 16'hB222 && nr == 0, "R3 new tag hits", rd, 16'hB222);
    access(0, 8'h05, 0, rd, nc, nr, nw, lg);
    chk(nr == 1 && nw == 0 && rd == 16'hA111, "R3 old tag misses and refills", rd, 16'hA111);
  endtask

  task automatic t_no_alloc_wt();
    do_reset(1'b0, 1'b0);
    access(0, 8'h0A, 0, rd, nc, nr, nw, lg);
    access(1, 8'h2A, 16'hC333, rd, nc, nr, nw, lg);
    chk(nw == 1 && nr == 0, "R4 no-alloc store writes memory", nw, 1);
    access(0, 8'h0A, 0, rd, nc, nr, nw, lg);
    chk(rd == init_val(10) && nr == 0, "R4 line unchanged after no-alloc miss", rd, init_val(10));
    access(0, 8'h2A, 0, rd, nc, nr, nw, lg);
    chk(rd == 16'hC333 && nr == 1, "R4 stored word from memory", rd, 16'hC333);
  endtask

  task automatic t_write_back();
    do_reset(1'b1, 1'b1);
    access(0, 8'h03, 0, rd, nc, nr, nw, lg);
    access(1, 8'h03, 16'hD444, rd, nc, nr, nw, lg);
    chk(nr + nw == 0 && nc == 0, "R5 WB store hit no traffic", nc * 256 + nr + nw, 0);
    chk(mem[3] == init_val(3), "R5 memory not written on hit", mem[3], init_val(3));
    access(0, 8'h23, 0, rd, nc, nr, nw, lg);
    chk(nw == 1 && nr == 1, "R6 dirty eviction write then read", nw * 16 + nr, 17);
    chk(log_we[lg % 64] && log_addr[lg % 64] == 8'h03 && log_data[lg % 64] == 16'hD444,
        "R6 evicted word and address", log_addr[lg % 64], 8'h03);
    chk(!log_we[(lg + 1) % 64] && log_addr[(lg + 1) % 64] == 8'h23, "R6 refill after write-back",
        log_addr[(lg + 1) % 64], 8'h23);
    chk(rd == init_val(8'h23), "R7 refill data after eviction", rd, init_val(8'h23));
    access(0, 8'h03, 0, rd, nc, nr, nw, lg);
    chk(nw == 0 && nr == 1 && rd == 16'hD444, "R7 refilled line clean", nw, 0);
    access(1, 8'h44, 16'hE555, rd, nc, nr, nw, lg);
    chk(nr + nw == 0 && nc == 0, "R10 WB alloc install no traffic", nc * 256 + nr + nw, 0);
    access(0, 8'h44, 0, rd, nc, nr, nw, lg);
    chk(rd == 16'hE555 && nr == 0, "R10 installed word hits", rd, 16'hE555);
    access(1, 8'h64, 16'hF666, rd, nc, nr, nw, lg);
    chk(nw == 1 && nr == 0 && log_addr[lg % 64] == 8'h44 && log_data[lg % 64] == 16'hE555,
        "R6 store miss evicts dirty word", log_addr[lg % 64], 8'h44);
    access(0, 8'h64, 0, rd, nc, nr, nw, lg);
    chk(rd == 16'hF666 && nr == 0, "R6 new word installed", rd, 16'hF666);
  endtask

  task automatic t_no_alloc_wb();
    do_reset(1'b1, 1'b0);
    access(1, 8'h11, 16'h7777, rd, nc, nr, nw, lg);
    chk(nw == 1 && nr == 0, "R4 WB no-alloc store to memory", nw, 1);
    access(0, 8'h11, 0, rd, nc, nr, nw, lg);
    chk(nr == 1 && rd == 16'h7777, "R4 WB no-alloc line not installed", rd, 16'h7777);
  endtask

  task automatic t_latency();
    do_reset(1'b0, 1'b1);
    for (int l = 0; l < 5; l++) begin
      lat = l;
      access(0, AW'(8'h80 + l), 0, rd, nc, nr, nw, lg);
      chk(nr == 1 && rd == init_val(8'h80 + l), "R9 data at latency", rd, init_val(8'h80 + l));
      chk(nc > l, "R9 stall covers latency", nc, l + 1);
    end
    lat = 1;
  endtask

  initial begin
    rst_n = 1'b0; cfg_wb = 1'b0; cfg_al = 1'b1;
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    t_reset_and_fill();
    t_write_through();
    t_no_alloc_wt();
    t_write_back();
    t_no_alloc_wb();
    t_latency();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule